// File: doc/BRIEF.md
# Page Write Buffer Controller

This block gathers write bytes for a 512-byte nonvolatile array that is organised as 32 rows (pages) of 16 bytes each. It then transfers the gathered bytes into the array during a self-timed programming interval. A write session opens with a load that carries a full 9-bit start address. That load latches the page (row) and the starting column. Each later load in the session places its byte at the next column. The column wraps inside the page and the row stays fixed, so a session of more than 16 bytes overwrites bytes loaded earlier in the same session.

A commit request closes the session. If at least one byte is loaded and write protect is low, the block raises `busy` for a fixed number of clock cycles set by `PROG_CYCLES`. During that interval it writes only the columns that were loaded into the behavioural array, through its write port. The other bytes of the page keep their old contents. While `busy` is high, all loads and commits are ignored. A commit with nothing loaded, or with write protect high, discards the session and finishes at once, without asserting `busy`. A read port returns array contents at any time.

Top module: `page_wbuf_ctrl`

## Requirements
- R1: In the cycle after reset, `busy` and `mem_we` are low, every array byte reads 0 and no bytes are loaded, so a commit made right after reset does not raise `busy`.
- R2: A load with `ld_first` high latches the row from `ld_addr[8:4]` and the column from `ld_addr[3:0]`. It clears any bytes loaded earlier and stores its byte at that address.
- R3: After each accepted load the column advances by one. Column 15 is followed by column 0 of the same row, and the row does not change. A later byte for a column replaces the earlier one.
- R4: At commit, only the columns that were loaded are written to the array. All other bytes of that page keep their previous values.
- R5: A commit in standby with at least one byte loaded and `wp` low raises `busy` in the next cycle. `busy` then stays high for exactly max(`PROG_CYCLES`, 16) cycles. Array writes (`mem_we`) occur only while `busy` is high.
- R6: A commit made with no bytes loaded, or with `wp` high, does not raise `busy`, and it discards any loaded bytes.
- R7: `mem_we` is never high while `wp` is high. A byte whose write cycle falls while `wp` is high is not written.
- R8: While `busy` is high, loads and commits have no effect on the array, on the loaded bytes or on the address state.
- R9: `rd_data` returns the array byte at `rd_addr` at all times, whatever the levels of `wp` and `busy`.
- R10: When a load and a commit arrive in the same standby cycle, the commit is acted on and the load is dropped.
- R11: When programming ends, the loaded bytes are cleared, so a following commit with no new loads does not raise `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load strobe: one data byte to be gathered |
| ld_first | input | 1 | Qualifies a load as the start of a session; take row and column from `ld_addr` |
| ld_addr | input | 9 | Start byte address (row in bits 8:4, column in bits 3:0), used when `ld_first` is high |
| ld_data | input | 8 | Byte to be gathered |
| commit | input | 1 | Commit request that closes the session |
| wp | input | 1 | Write-protect level; high blocks all programming |
| busy | output | 1 | High during the programming interval |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 9 | Array write address |
| mem_wdata | output | 8 | Array write data |
| rd_addr | input | 9 | Array read address |
| rd_data | output | 8 | Array read data |

## Verification
The assertions check, on every cycle, the relations that can be seen locally. No write happens under write protect. Writes occur only inside the busy interval, and that interval has exactly the programmed length. The column steps by one with a wrap inside the page, the row and column stay frozen while busy, and a rejected commit never raises busy. What ends up in the array can only be shown by the bench's scenarios and its per-clock reference model: which bytes survive a wrapping session of 20 loads, whether untouched columns keep their contents, whether loads made during busy leave no trace, and that a byte whose write slot meets a write-protect pulse is lost while its neighbour lands.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    localparam int ROW_W       = 5;
    localparam int COL_W       = 4;
    localparam int DATA_W      = 8;
    localparam int ADDR_W      = ROW_W + COL_W;
    localparam int PAGE_BYTES  = 1 << COL_W;
    localparam int ARRAY_BYTES = 1 << ADDR_W;

    typedef logic [ROW_W-1:0]  row_t;
    typedef logic [COL_W-1:0]  col_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic {
        PH_STANDBY = 1'b0,
        PH_PROGRAM = 1'b1
    } phase_e;

    typedef struct packed {
        logic  first;
        addr_t addr;
        data_t data;
    } load_req_t;

    typedef struct packed {
        logic  we;
        addr_t addr;
        data_t data;
    } wr_port_t;

    function automatic col_t col_next(input col_t c);
        return c + col_t'(1);
    endfunction

    function automatic addr_t join_addr(input row_t r, input col_t c);
        return {r, c};
    endfunction

    function automatic row_t row_of(input addr_t a);
        return a[ADDR_W-1:COL_W];
    endfunction

    function automatic col_t col_of(input addr_t a);
        return a[COL_W-1:0];
    endfunction

endpackage

// File: rtl/pwb_addr_track.sv
module pwb_addr_track
    import pwb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      accept,
    input  load_req_t req,
    output col_t      wr_col,
    output row_t      row_q,
    output col_t      col_q
);

    // Column that the current load writes to
    always_comb begin
        if (req.first) wr_col = col_of(req.addr);
        else           wr_col = col_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q <= '0;
            col_q <= '0;
        end else if (accept) begin
            col_q <= col_next(wr_col);
            if (req.first) row_q <= row_of(req.addr);
        end
    end

endmodule

// File: rtl/pwb_page_buf.sv
module pwb_page_buf
    import pwb_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  accept,
    input  logic                  first,
    input  col_t                  wr_col,
    input  data_t                 wr_data,
    input  logic                  clear,
    input  col_t                  rd_col,
    output data_t                 rd_data,
    output logic [PAGE_BYTES-1:0] mask
);

    data_t slot [PAGE_BYTES];

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        data_t d_q;
        logic  v_q;
        logic  hit;

        assign hit = accept && (wr_col == col_t'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                d_q <= '0;
                v_q <= 1'b0;
            end else if (hit) begin
                d_q <= wr_data;
                v_q <= 1'b1;
            end else if (clear || (accept && first)) begin
                v_q <= 1'b0;
            end
        end

        assign slot[g] = d_q;
        assign mask[g] = v_q;
    end

    assign rd_data = slot[rd_col];

endmodule

// File: rtl/pwb_prog_seq.sv
module pwb_prog_seq
    import pwb_pkg::*;
#(
    parameter int PROG_CYCLES = 500000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   commit_req,
    input  logic   wp,
    input  logic   mask_any,
    output phase_e phase,
    output logic   busy,
    output logic   clear_mask,
    output logic   scan_en,
    output col_t   scan_col
);

    localparam int PROG_EFF = (PROG_CYCLES < PAGE_BYTES) ? PAGE_BYTES : PROG_CYCLES;
    localparam int TW       = $clog2(PROG_EFF + 1);
    localparam logic [TW-1:0] T_LAST = TW'(PROG_EFF - 1);
    localparam logic [TW-1:0] T_SCAN = TW'(PAGE_BYTES);

    logic [TW-1:0] timer_q;
    logic          start;
    logic          reject;
    logic          done;

    assign start  = (phase == PH_STANDBY) && commit_req && mask_any && !wp;
    assign reject = (phase == PH_STANDBY) && commit_req && (!mask_any || wp);
    assign done   = (phase == PH_PROGRAM) && (timer_q == T_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_STANDBY;
            timer_q <= '0;
        end else begin
            unique case (phase)
                PH_STANDBY: begin
                    timer_q <= '0;
                    if (start) phase <= PH_PROGRAM;
                end
                PH_PROGRAM: begin
                    if (done) begin
                        phase   <= PH_STANDBY;
                        timer_q <= '0;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                default: phase <= PH_STANDBY;
            endcase
        end
    end

    assign busy       = (phase == PH_PROGRAM);
    assign clear_mask = reject || done;
    assign scan_en    = busy && (timer_q < T_SCAN);
    assign scan_col   = timer_q[COL_W-1:0];

endmodule

// File: rtl/pwb_array.sv
module pwb_array
    import pwb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  wr_port_t port,
    input  addr_t    rd_addr,
    output data_t    rd_data
);

    data_t cells [ARRAY_BYTES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ARRAY_BYTES; i++) cells[i] <= '0;
        end else if (port.we) begin
            cells[port.addr] <= port.data;
        end
    end

    assign rd_data = cells[rd_addr];

endmodule

// File: rtl/page_wbuf_ctrl.sv
module page_wbuf_ctrl
    import pwb_pkg::*;
#(
    parameter int PROG_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_valid,
    input  logic              ld_first,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              commit,
    input  logic              wp,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    phase_e                phase;
    load_req_t             req;
    logic                  standby;
    logic                  load_accept;
    logic                  commit_req;
    col_t                  wr_col;
    col_t                  col_q;
    row_t                  row_q;
    logic [PAGE_BYTES-1:0] mask_q;
    logic                  clear_mask;
    logic                  scan_en;
    col_t                  scan_col;
    data_t                 slot_data;
    wr_port_t              wport;

    assign req         = '{first: ld_first, addr: ld_addr, data: ld_data};
    assign standby     = (phase == PH_STANDBY);
    assign commit_req  = commit && standby;
    assign load_accept = ld_valid && standby && !commit;   // commit wins a tie

    pwb_addr_track u_track (
        .clk    (clk),
        .rst    (rst),
        .accept (load_accept),
        .req    (req),
        .wr_col (wr_col),
        .row_q  (row_q),
        .col_q  (col_q)
    );

    pwb_page_buf u_buf (
        .clk     (clk),
        .rst     (rst),
        .accept  (load_accept),
        .first   (req.first),
        .wr_col  (wr_col),
        .wr_data (req.data),
        .clear   (clear_mask),
        .rd_col  (scan_col),
        .rd_data (slot_data),
        .mask    (mask_q)
    );

    pwb_prog_seq #(.PROG_CYCLES(PROG_CYCLES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .commit_req (commit_req),
        .wp         (wp),
        .mask_any   (|mask_q),
        .phase      (phase),
        .busy       (busy),
        .clear_mask (clear_mask),
        .scan_en    (scan_en),
        .scan_col   (scan_col)
    );

    // Write-protect gates every individual array write
    assign wport.we   = scan_en && mask_q[scan_col] && !wp;
    assign wport.addr = join_addr(row_q, scan_col);
    assign wport.data = slot_data;

    pwb_array u_array (
        .clk     (clk),
        .rst     (rst),
        .port    (wport),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign mem_we    = wport.we;
    assign mem_addr  = wport.addr;
    assign mem_wdata = wport.data;

endmodule

// File: rtl/pwb_checker.sv
module pwb_checker
    import pwb_pkg::*;
#(
    parameter int PROG_CYCLES = 500000
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  ld_valid,
    input logic                  ld_first,
    input logic [ADDR_W-1:0]     ld_addr,
    input logic                  commit,
    input logic                  wp,
    input logic                  busy,
    input logic                  mem_we,
    input logic [PAGE_BYTES-1:0] mask_q,
    input row_t                  row_q,
    input col_t                  col_q
);

    localparam int PROG_EFF = (PROG_CYCLES < PAGE_BYTES) ? PAGE_BYTES : PROG_CYCLES;

    int unsigned busy_run;

    always_ff @(posedge clk) begin
        if (rst)       busy_run <= 0;
        else if (busy) busy_run <= busy_run + 1;
        else           busy_run <= 0;
    end

    AST_NO_WRITE_WP: assert property (@(posedge clk) disable iff (rst)
        wp |-> !mem_we);  // R7

    AST_WRITE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> busy);  // R5

    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        (!busy && commit && !wp && (mask_q != '0)) |=> busy);  // R5

    AST_BUSY_LEN_MAX: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_run < PROG_EFF));  // R5

    AST_BUSY_LEN_MIN: assert property (@(posedge clk) disable iff (rst)
        (!busy && busy_run != 0) |-> (busy_run == PROG_EFF));  // R5

    AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && commit && (wp || mask_q == '0)) |=> (!busy && mask_q == '0));  // R6

    AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !busy && !commit) |=>
            (col_q == col_t'((ld_first ? ld_addr[COL_W-1:0] : col_q) + 1'b1) ||
             col_q == ($past(ld_first) ? col_t'($past(ld_addr[COL_W-1:0]) + 1'b1)
                                       : col_t'($past(col_q) + 1'b1))));  // R3

    AST_ROW_KEEP: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !ld_first && !busy && !commit) |=> $stable(row_q));  // R3

    AST_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(row_q) && $stable(col_q)));  // R8

endmodule

bind page_wbuf_ctrl pwb_checker #(.PROG_CYCLES(PROG_CYCLES)) u_pwb_checker (
    .clk      (clk),
    .rst      (rst),
    .ld_valid (ld_valid),
    .ld_first (ld_first),
    .ld_addr  (ld_addr),
    .commit   (commit),
    .wp       (wp),
    .busy     (busy),
    .mem_we   (mem_we),
    .mask_q   (mask_q),
    .row_q    (row_q),
    .col_q    (col_q)
);

// File: tb/test_page_wbuf_ctrl.sv
module test_page_wbuf_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int PROG       = 40;
    localparam int WATCHDOG   = 50000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ld_valid = 1'b0;
    logic       ld_first = 1'b0;
    logic [8:0] ld_addr = '0;
    logic [7:0] ld_data = '0;
    logic       commit = 1'b0;
    logic       wp = 1'b0;
    logic       busy;
    logic       mem_we;
    logic [8:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [8:0] rd_addr = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit started = 0;
    bit done_rep = 0;

    page_wbuf_ctrl #(.PROG_CYCLES(PROG)) i_page_wbuf_ctrl (
        .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_first(ld_first),
        .ld_addr(ld_addr), .ld_data(ld_data), .commit(commit), .wp(wp),
        .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model state
    bit [7:0]  m_mem [512];
    bit [7:0]  m_slot [16];
    bit [15:0] m_mask;
    int        m_row, m_col, m_t;
    bit        m_busy;
    int        q [$];   // pending writes: (addr << 8) | data, in column order

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic report;
        if (!done_rep) begin
            done_rep = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WATCHDOG) begin
            checks++; fails++;
            $display("FAIL all watchdog expired actual=%0d expected=<%0d", cyc, WATCHDOG);
            report();
        end
        if (rst) begin
            foreach (m_mem[i]) m_mem[i] = 0;
            m_mask = 0; m_row = 0; m_col = 0; m_t = 0; m_busy = 0; q.delete();
        end else if (m_busy) begin
            if (m_t < 16 && q.size() > 0 && (((q[0] >> 8) % 16) == m_t)) begin
                if (!wp) m_mem[q[0] >> 8] = 8'(q[0] & 255);
                void'(q.pop_front());
            end
            m_t++;
            if (m_t == PROG) begin m_busy = 0; m_mask = 0; end
        end else if (commit) begin
            if (m_mask != 0 && !wp) begin
                q.delete();
                for (int c = 0; c < 16; c++)
                    if (m_mask[c]) q.push_back(((m_row * 16 + c) << 8) | int'(m_slot[c]));
                m_busy = 1; m_t = 0;
            end else begin
                m_mask = 0;
            end
        end else if (ld_valid) begin
            int c;
            c = ld_first ? int'(ld_addr) % 16 : m_col;
            if (ld_first) begin m_row = int'(ld_addr) / 16; m_mask = 0; end
            m_slot[c] = ld_data;
            m_mask[c] = 1'b1;
            m_col = (c + 1) % 16;
        end
        started = 1;
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (started && !rst) begin
            bit e_we;
            e_we = m_busy && m_t < 16 && q.size() > 0 && (((q[0] >> 8) % 16) == m_t) && !wp;
            check(busy == m_busy, "R5 busy vs model", busy, m_busy);
            check(mem_we == e_we, "R4/R7 mem_we vs model", mem_we, e_we);
            if (e_we) begin
                check(mem_addr == 9'(q[0] >> 8), "R2 mem_addr vs model", mem_addr, q[0] >> 8);
                check(mem_wdata == 8'(q[0] & 255), "R3 mem_wdata vs model", mem_wdata, q[0] & 255);
            end
            check(rd_data == m_mem[rd_addr], "R9 rd_data vs model", rd_data, m_mem[rd_addr]);
        end
    end

    task automatic load(input bit first, input int addr, input int data);
        ld_valid = 1; ld_first = first; ld_addr = 9'(addr); ld_data = 8'(data);
        @(posedge clk); #1;
        ld_valid = 0; ld_first = 0;
    endtask

    task automatic do_commit;
        commit = 1;
        @(posedge clk); #1;
        commit = 0;
    endtask

    task automatic wait_idle;
        @(negedge clk);
        while (busy) @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic expect_rd(input int addr, input int exp, input string tag);
        rd_addr = 9'(addr);
        #2;
        check(rd_data == 8'(exp), tag, rd_data, exp);
    endtask

    task automatic expect_no_busy(input string tag);
        @(negedge clk);
        check(busy == 1'b0, tag, busy, 0);
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;

        // R1: reset state
        #2;
        check(busy == 0, "R1 busy after reset", busy, 0);
        check(mem_we == 0, "R1 mem_we after reset", mem_we, 0);
        expect_rd(9'h000, 8'h00, "R1 array clear after reset");
        @(posedge clk); #1;
        do_commit();
        expect_no_busy("R1 commit with nothing loaded after reset");

        // R2, R5: single byte, busy length
        load(1, 9'h123, 8'hA5);
        do_commit();
        begin
            int n = 0;
            @(negedge clk);
            while (busy) begin n++; @(negedge clk); end
            check(n == PROG, "R5 busy length", n, PROG);
            @(posedge clk); #1;
        end
        expect_rd(9'h123, 8'hA5, "R2 byte at start address");
        expect_rd(9'h122, 8'h00, "R4 neighbour below untouched");
        expect_rd(9'h124, 8'h00, "R4 neighbour above untouched");

        // R3: 20 bytes from column 10 of row 5, wrapping
        for (int i = 0; i < 20; i++) load(i == 0, 9'h05A, 8'h10 + i);
        do_commit();
        wait_idle();
        expect_rd(9'h05A, 8'h20, "R3 wrapped byte overwrites col 10");
        expect_rd(9'h05D, 8'h23, "R3 wrapped byte overwrites col 13");
        expect_rd(9'h05F, 8'h15, "R3 col 15 keeps first pass");
        expect_rd(9'h050, 8'h16, "R3 wrap lands at col 0 same row");
        expect_rd(9'h060, 8'h00, "R3 next row untouched");
        expect_rd(9'h04F, 8'h00, "R3 previous row untouched");

        // R4: partial page keeps other bytes
        load(1, 9'h052, 8'h77);
        do_commit();
        wait_idle();
        expect_rd(9'h052, 8'h77, "R4 loaded column written");
        expect_rd(9'h053, 8'h19, "R4 unloaded column kept");

        // R6, R9: write protect at commit
        load(1, 9'h100, 8'h3C);
        wp = 1;
        do_commit();
        expect_no_busy("R6 commit under wp no busy");
        expect_rd(9'h100, 8'h00, "R6 protected byte not written");
        expect_rd(9'h05A, 8'h20, "R9 read under wp");
        wp = 0;
        do_commit();
        expect_no_busy("R6 bytes discarded after protected commit");

        // R8, R9, R11: activity during busy is ignored
        load(1, 9'h1F0, 8'h11);
        do_commit();
        repeat (3) @(posedge clk);
        #1;
        expect_rd(9'h123, 8'hA5, "R9 read during busy");
        load(1, 9'h030, 8'h99);
        do_commit();
        wait_idle();
        expect_rd(9'h030, 8'h00, "R8 load during busy ignored");
        expect_rd(9'h1F0, 8'h11, "R8 programmed byte intact");
        do_commit();
        expect_no_busy("R11 bytes cleared after programming");

        // R3: wrap in the last row stays in that row
        load(1, 9'h1FF, 8'hE1);
        load(0, 9'h000, 8'hE2);
        do_commit();
        wait_idle();
        expect_rd(9'h1FF, 8'hE1, "R3 last column of last row");
        expect_rd(9'h1F0, 8'hE2, "R3 wrap to col 0 of last row");
        expect_rd(9'h000, 8'h00, "R3 row 0 not reached");

        // R10: load and commit together
        ld_valid = 1; ld_first = 1; ld_addr = 9'h040; ld_data = 8'h55;
        commit = 1;
        @(posedge clk); #1;
        ld_valid = 0; ld_first = 0; commit = 0;
        expect_no_busy("R10 tie with nothing loaded no busy");
        expect_rd(9'h040, 8'h00, "R10 tied load dropped");
        load(1, 9'h041, 8'h66);
        ld_valid = 1; ld_first = 0; ld_data = 8'h67; commit = 1;
        @(posedge clk); #1;
        ld_valid = 0; commit = 0;
        wait_idle();
        expect_rd(9'h041, 8'h66, "R10 earlier byte programmed");
        expect_rd(9'h042, 8'h00, "R10 tied byte dropped");

        // R7: wp pulse during the slot of column 0
        load(1, 9'h0E0, 8'hC1);
        load(0, 9'h000, 8'hC2);
        do_commit();
        wp = 1;
        @(posedge clk); #1;
        wp = 0;
        wait_idle();
        expect_rd(9'h0E0, 8'h00, "R7 byte blocked by wp pulse");
        expect_rd(9'h0E1, 8'hC2, "R7 next byte written");

        repeat (2) @(posedge clk);
        report();
    end

endmodule